// File: doc/BRIEF.md
# Double-Word Funnel Shift Unit

This unit executes one funnel-shift operation per valid cycle. Two 32-bit words, a low word and a high word, form a 64-bit funnel. The unit shifts that funnel left or right and returns one 32-bit slice of it. The shift amount comes either from a register operand or from a 6-bit immediate taken from the instruction word. That amount is then either wrapped or clamped to the working size. The working size is 32 in the 32-bit mode and 64 in the two 64-bit modes, unsigned and signed.

The unit extracts its mode fields directly from the 64-bit instruction word. A shift by 0 and a shift by exactly 32 each return a fixed word, and that word depends on the mode and the direction. Inside the datapath, any 32-bit partial shift by exactly 32 yields zero, so a shift never wraps around. The unit does not handle extended modes or condition-code generation. When an instruction asks for either of them, or uses the reserved type code, the unit raises an `unsupported` flag but still computes the plain result.

The result is registered, so it appears one cycle after the input. A valid strobe travels alongside it with the same one-cycle delay.

Top module: `dword_funnel_shifter`

## Requirements
- R1: The unit decodes four fields from the instruction word and ignores every other bit.
  - Operand type is in bits 38:37, coded 0 = 32-bit, 2 = unsigned 64-bit, 3 = signed 64-bit.
  - Extended mode is in bits 49:48.
  - Wrap flag is in bit 50.
  - The 6-bit immediate amount is in bits 25:20.
  - Type code 1 is reserved and is executed as 32-bit.
- R2: With the wrap flag at 1, the effective amount is the raw amount ANDed with (size − 1). Size is 32 for type 0 or 1, and 64 for type 2 or 3.
- R3: With the wrap flag at 0, the raw amount is read as a signed 32-bit value and clamped into 0..size inclusive.
- R4: With `use_imm` at 1, the zero-extended immediate field replaces `shamt_reg` as the raw amount. With `use_imm` at 0, the immediate field has no effect.
- R5: A right shift by s with 0 < s < 32 gives (lo >> s) | (hi << (32 − s)) in every mode.
- R6: In 32-bit mode, a right shift by 32 returns hi, and a right shift by 0 returns lo.
- R7: In the 64-bit modes, a right shift behaves as follows:
  - By 0 it returns hi.
  - By s with 32 ≤ s < 64 it returns hi >> (s − 32). The shift is arithmetic for type 3 and logical for type 2.
  - By 64 it returns 0 in both 64-bit modes.
- R8: A left shift by s with 0 < s < 32 gives (lo >> (32 − s)) | (hi << s). In 32-bit mode, a left shift by 32 returns lo, and a left shift by 0 returns hi.
- R9: In the 64-bit modes, a left shift behaves as follows:
  - By 0 it returns hi.
  - By s with 32 ≤ s < 64 it returns lo << (s − 32).
  - By 64 it returns 0.
- R10: `unsupported` is 1 when any of these holds: the extended-mode field is nonzero, `gen_cc` is 1, or the type is the reserved code. The result is computed as if the extended mode were zero.
- R11: `out_valid` equals `in_valid` delayed by one clock. `result` and `unsupported` update only on cycles where `in_valid` is 1, and hold their values otherwise.
- R12: While `rst` is 1 at a clock edge, the next state is `out_valid` = 0, `result` = 0 and `unsupported` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| insn | input | 64 | Instruction word holding the mode fields |
| use_imm | input | 1 | Take the shift amount from the immediate field |
| gen_cc | input | 1 | Instruction requests condition codes (unsupported) |
| dir_left | input | 1 | 1 = left funnel shift, 0 = right |
| shamt_reg | input | 32 | Register shift amount, signed |
| lo_word | input | 32 | Low word of the funnel |
| hi_word | input | 32 | High word of the funnel |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 32 | Selected 32-bit slice |
| unsupported | output | 1 | Extended mode, condition codes or reserved type requested |

## Verification
The bench concentrates on the amounts 0, 32 and 64, because each mode defines its own answer for these. A design that let a 32-bit partial shift wrap would return a mixed word where zero or a fixed word is expected. It also checks signed 64-bit right shifts with a negative high word. A design that confused arithmetic and logical shifting would show the wrong upper byte, and a design that sign-filled at an amount of 64 would return all ones instead of zero. Negative and oversized register amounts check the clamp, and amounts of 64 and −1 check the wrap. Setting instruction bits outside the four fields checks that the decode ignores them. The bench also checks that the reserved type runs as 32-bit, which a design that misdecoded it as 64-bit would get wrong.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  typedef enum logic [1:0] {
    TY_W32 = 2'd0,
    TY_RSV = 2'd1,
    TY_U64 = 2'd2,
    TY_S64 = 2'd3
  } op_type_e;

  // Field positions inside the instruction word (decoded by this unit)
  localparam int TYPE_LSB  = 37;
  localparam int XMODE_LSB = 48;
  localparam int WRAP_BIT  = 50;
  localparam int IMM_LSB   = 20;
  localparam int IMM_W     = 6;

  typedef struct packed {
    op_type_e         ty;
    logic [1:0]       xmode;
    logic             wrap;
    logic [IMM_W-1:0] imm;
  } fields_t;

endpackage

// File: rtl/fsh_decode.sv
module fsh_decode
  import fsh_pkg::*;
#(
  parameter int INSN_W = 64
) (
  input  logic [INSN_W-1:0] insn,
  input  logic              gen_cc,
  output fields_t           fld,
  output logic              is64,
  output logic              is_signed,
  output logic              unsup
);

  localparam logic [INSN_W-1:0] FIELD_MASK =
      (INSN_W'(2'b11) << TYPE_LSB) | (INSN_W'(2'b11) << XMODE_LSB) |
      (INSN_W'(1'b1) << WRAP_BIT)  | (INSN_W'({IMM_W{1'b1}}) << IMM_LSB);

  logic unused_insn_bits;
  assign unused_insn_bits = ^(insn & ~FIELD_MASK);

  always_comb begin
    fld.ty    = op_type_e'(insn[TYPE_LSB +: 2]);
    fld.xmode = insn[XMODE_LSB +: 2];
    fld.wrap  = insn[WRAP_BIT];
    fld.imm   = insn[IMM_LSB +: IMM_W];
    is64      = (fld.ty == TY_U64) || (fld.ty == TY_S64);
    is_signed = (fld.ty == TY_S64);
    unsup     = (fld.xmode != 2'b00) || gen_cc || (fld.ty == TY_RSV);
  end

endmodule

// File: rtl/fsh_amount.sv
module fsh_amount
  import fsh_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 32,
  parameter int SH_W  = $clog2(2 * W + 1)
) (
  input  logic [AMT_W-1:0] shamt_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic             is64,
  input  logic             wrap,
  output logic [SH_W-1:0]  amt
);

  localparam logic [AMT_W-1:0] SIZE_NARROW = AMT_W'(W);
  localparam logic [AMT_W-1:0] SIZE_WIDE   = AMT_W'(2 * W);

  logic [AMT_W-1:0] raw;
  logic [AMT_W-1:0] size_ext;

  always_comb begin
    raw      = use_imm ? AMT_W'(imm) : shamt_reg;
    size_ext = is64 ? SIZE_WIDE : SIZE_NARROW;
    if (wrap)
      amt = SH_W'(raw & (size_ext - AMT_W'(1)));
    else if (raw[AMT_W-1])
      amt = '0;
    else if (raw > size_ext)
      amt = SH_W'(size_ext);
    else
      amt = SH_W'(raw);
  end

endmodule

// File: rtl/fsh_core.sv
module fsh_core #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(2 * W + 1)
) (
  input  logic [W-1:0]    lo,
  input  logic [W-1:0]    hi,
  input  logic [SH_W-1:0] amt,
  input  logic            dir_left,
  input  logic            is64,
  input  logic            is_signed,
  output logic [W-1:0]    res
);

  localparam logic [SH_W-1:0] WL = SH_W'(W);

  // Partial shifts: an amount of a full word yields zero instead of wrapping
  function automatic logic [W-1:0] part_shr(input logic [W-1:0] x,
                                            input logic [SH_W-1:0] a,
                                            input logic arith);
    if (a >= WL) return '0;
    if (arith) return $unsigned($signed(x) >>> a);
    return x >> a;
  endfunction

  function automatic logic [W-1:0] part_shl(input logic [W-1:0] x,
                                            input logic [SH_W-1:0] a);
    if (a >= WL) return '0;
    return x << a;
  endfunction

  logic [SH_W-1:0] comp;
  logic [SH_W-1:0] upper;
  logic [W-1:0]    r_near, l_near, r_far, l_far;
  logic [W-1:0]    r_res, l_res;

  always_comb begin
    comp   = WL - amt;
    upper  = amt - WL;
    r_near = part_shr(lo, amt, 1'b0) | part_shl(hi, comp);
    l_near = part_shr(lo, comp, 1'b0) | part_shl(hi, amt);
    r_far  = part_shr(hi, upper, is_signed);
    l_far  = part_shl(lo, upper);
    if (!is64) begin
      r_res = (amt == WL) ? hi : r_near;
      l_res = (amt == WL) ? lo : l_near;
    end else begin
      r_res = (amt == '0) ? hi : ((amt < WL) ? r_near : r_far);
      l_res = (amt == '0) ? hi : ((amt < WL) ? l_near : l_far);
    end
    res = dir_left ? l_res : r_res;
  end

endmodule

// File: rtl/dword_funnel_shifter.sv
module dword_funnel_shifter
  import fsh_pkg::*;
#(
  parameter int W      = 32,
  parameter int AMT_W  = 32,
  parameter int INSN_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic              use_imm,
  input  logic              gen_cc,
  input  logic              dir_left,
  input  logic [AMT_W-1:0]  shamt_reg,
  input  logic [W-1:0]      lo_word,
  input  logic [W-1:0]      hi_word,
  output logic              out_valid,
  output logic [W-1:0]      result,
  output logic              unsupported
);

  localparam int SH_W = $clog2(2 * W + 1);

  fields_t         fld;
  logic            is64, is_signed, unsup_c;
  logic [SH_W-1:0] amt;
  logic [W-1:0]    res_c;

  fsh_decode #(.INSN_W(INSN_W)) u_decode (
    .insn(insn), .gen_cc(gen_cc), .fld(fld),
    .is64(is64), .is_signed(is_signed), .unsup(unsup_c)
  );

  fsh_amount #(.W(W), .AMT_W(AMT_W), .SH_W(SH_W)) u_amount (
    .shamt_reg(shamt_reg), .imm(fld.imm), .use_imm(use_imm),
    .is64(is64), .wrap(fld.wrap), .amt(amt)
  );

  fsh_core #(.W(W), .SH_W(SH_W)) u_core (
    .lo(lo_word), .hi(hi_word), .amt(amt), .dir_left(dir_left),
    .is64(is64), .is_signed(is_signed), .res(res_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      result      <= '0;
      unsupported <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result      <= res_c;
        unsupported <= unsup_c;
      end
    end
  end

  AST_WRAP_BELOW_SIZE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[WRAP_BIT]) |-> (amt < (is64 ? SH_W'(2 * W) : SH_W'(W)))); // R2
  AST_CLAMP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !insn[WRAP_BIT]) |-> (amt <= (is64 ? SH_W'(2 * W) : SH_W'(W)))); // R3
  AST_UNSUP_RAISE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (insn[XMODE_LSB +: 2] != 2'b00 || gen_cc)) |=> unsupported); // R10
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && !out_valid)); // R11
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !unsupported)); // R12

endmodule

// File: tb/dword_funnel_shifter_bench.sv
module dword_funnel_shifter_bench;

  typedef struct packed {
    logic        left;
    logic        imm_sel;
    logic        cc;
    logic [1:0]  ty;
    logic [1:0]  xm;
    logic        wr;
    logic [31:0] amt;
    logic [5:0]  imm;
    logic [31:0] exp;
    logic        unsup;
    logic [7:0]  req;
  } vec_t;

  localparam logic [31:0] LW = 32'h1234_5678;
  localparam logic [31:0] HW = 32'h9ABC_DEF0;
  localparam int NV = 30;

  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,32'd8,6'd5,32'hF012_3456,1'b0,8'd5},   // R5, R4 imm ignored
    '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,32'd0,6'd0,32'h1234_5678,1'b0,8'd6},   // R6
    '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,32'd32,6'd0,32'h9ABC_DEF0,1'b0,8'd6},  // R6
    '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,32'd100,6'd0,32'h9ABC_DEF0,1'b0,8'd3}, // R3
    '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,32'hFFFF_FFFB,6'd0,32'h1234_5678,1'b0,8'd3}, // R3
    '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b1,32'd40,6'd0,32'hF012_3456,1'b0,8'd2},  // R2
    '{1'b0,1'b0,1'b0,2'd2,2'd0,1'b0,32'd40,6'd0,32'h009A_BCDE,1'b0,8'd7},  // R7
    '{1'b0,1'b0,1'b0,2'd3,2'd0,1'b0,32'd40,6'd0,32'hFF9A_BCDE,1'b0,8'd7},  // R7
    '{1'b0,1'b0,1'b0,2'd3,2'd0,1'b0,32'd0,6'd0,32'h9ABC_DEF0,1'b0,8'd7},   // R7
    '{1'b0,1'b0,1'b0,2'd3,2'd0,1'b0,32'd32,6'd0,32'h9ABC_DEF0,1'b0,8'd7},  // R7
    '{1'b0,1'b0,1'b0,2'd3,2'd0,1'b0,32'd200,6'd0,32'h0000_0000,1'b0,8'd7}, // R7
    '{1'b0,1'b0,1'b0,2'd3,2'd0,1'b1,32'd100,6'd0,32'hF9AB_CDEF,1'b0,8'd2}, // R2
    '{1'b0,1'b0,1'b0,2'd2,2'd0,1'b0,32'd8,6'd0,32'hF012_3456,1'b0,8'd5},   // R5
    '{1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,32'd8,6'd0,32'hBCDE_F012,1'b0,8'd8},   // R8
    '{1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,32'd32,6'd0,32'h1234_5678,1'b0,8'd8},  // R8
    '{1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,32'd0,6'd0,32'h9ABC_DEF0,1'b0,8'd8},   // R8
    '{1'b1,1'b0,1'b0,2'd2,2'd0,1'b0,32'd40,6'd0,32'h3456_7800,1'b0,8'd9},  // R9
    '{1'b1,1'b0,1'b0,2'd2,2'd0,1'b0,32'd32,6'd0,32'h1234_5678,1'b0,8'd9},  // R9
    '{1'b1,1'b0,1'b0,2'd3,2'd0,1'b0,32'd0,6'd0,32'h9ABC_DEF0,1'b0,8'd9},   // R9
    '{1'b1,1'b0,1'b0,2'd2,2'd0,1'b0,32'd64,6'd0,32'h0000_0000,1'b0,8'd9},  // R9
    '{1'b0,1'b1,1'b0,2'd0,2'd0,1'b0,32'd3,6'd8,32'hF012_3456,1'b0,8'd4},   // R4
    '{1'b1,1'b1,1'b0,2'd0,2'd0,1'b0,32'd3,6'd63,32'h1234_5678,1'b0,8'd4},  // R4
    '{1'b0,1'b0,1'b0,2'd1,2'd0,1'b0,32'd40,6'd0,32'h9ABC_DEF0,1'b1,8'd1},  // R1 reserved type
    '{1'b0,1'b0,1'b0,2'd2,2'd2,1'b0,32'd40,6'd0,32'h009A_BCDE,1'b1,8'd10}, // R10
    '{1'b1,1'b0,1'b1,2'd0,2'd0,1'b0,32'd8,6'd0,32'hBCDE_F012,1'b1,8'd10},  // R10
    '{1'b1,1'b0,1'b0,2'd2,2'd0,1'b0,32'd4,6'd0,32'hABCD_EF01,1'b0,8'd8},   // R8
    '{1'b0,1'b0,1'b0,2'd2,2'd0,1'b1,32'd64,6'd0,32'h9ABC_DEF0,1'b0,8'd2},  // R2
    '{1'b1,1'b0,1'b0,2'd0,2'd0,1'b1,32'd32,6'd0,32'h9ABC_DEF0,1'b0,8'd2},  // R2
    '{1'b1,1'b1,1'b0,2'd2,2'd0,1'b0,32'd0,6'd40,32'h3456_7800,1'b0,8'd4},  // R4
    '{1'b0,1'b0,1'b0,2'd2,2'd0,1'b1,32'hFFFF_FFFF,6'd0,32'h0000_0001,1'b0,8'd2} // R2
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] insn = '0;
  logic        use_imm = 1'b0;
  logic        gen_cc = 1'b0;
  logic        dir_left = 1'b0;
  logic [31:0] shamt_reg = '0;
  logic [31:0] lo_word = '0;
  logic [31:0] hi_word = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        unsupported;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dword_funnel_shifter u_dword_funnel_shifter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .use_imm(use_imm), .gen_cc(gen_cc), .dir_left(dir_left),
    .shamt_reg(shamt_reg), .lo_word(lo_word), .hi_word(hi_word),
    .out_valid(out_valid), .result(result), .unsupported(unsupported)
  );

  // R1: junk outside the fields must not matter
  function automatic logic [63:0] mk_insn(input logic [1:0] ty, input logic [1:0] xm,
                                          input logic wr, input logic [5:0] im);
    logic [63:0] w;
    w = 64'hA5A5_A5A5_A5A5_A5A5;
    w[38:37] = ty;
    w[49:48] = xm;
    w[50]    = wr;
    w[25:20] = im;
    return w;
  endfunction

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got valid/unsup/result %h, expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk);
    in_valid  = 1'b1;
    dir_left  = v.left;
    use_imm   = v.imm_sel;
    gen_cc    = v.cc;
    shamt_reg = v.amt;
    insn      = mk_insn(v.ty, v.xm, v.wr, v.imm);
    lo_word   = lo;
    hi_word   = hi;
    @(negedge clk);
    check($sformatf("R%0d vector", v.req), {out_valid, unsupported, result},
          {1'b1, v.unsup, v.exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 reset", {out_valid, unsupported, result}, 34'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) apply(VECS[i], LW, HW);

    // R5: different word pair
    apply('{1'b0,1'b0,1'b0,2'd2,2'd0,1'b0,32'd16,6'd0,32'h0000_FFFF,1'b0,8'd5},
          32'hFFFF_FFFF, 32'h0000_0000);
    // R7: signed far shift of a positive high word stays positive
    apply('{1'b0,1'b0,1'b0,2'd3,2'd0,1'b0,32'd48,6'd0,32'h0000_7FFF,1'b0,8'd7},
          32'h0, 32'h7FFF_0000);

    // R11: drop valid, change inputs, result and flag must hold
    @(negedge clk);
    in_valid = 1'b0;
    shamt_reg = 32'd3;
    hi_word = 32'hDEAD_BEEF;
    gen_cc = 1'b1;
    @(negedge clk);
    check("R11 hold", {out_valid, unsupported, result}, {1'b0, 1'b0, 32'h0000_7FFF});
    @(negedge clk);
    check("R11 hold2", {out_valid, unsupported, result}, {1'b0, 1'b0, 32'h0000_7FFF});

    // R10 then R12: reset clears a raised flag and result
    apply('{1'b1,1'b0,1'b1,2'd0,2'd0,1'b0,32'd8,6'd0,32'hBCDE_F012,1'b1,8'd10}, LW, HW);
    rst = 1'b1;
    @(negedge clk);
    check("R12 mid-run reset", {out_valid, unsupported, result}, 34'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    gen_cc = 1'b0;
    @(negedge clk);
    check("R11 idle after reset", {out_valid, unsupported, result}, 34'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule